// File: doc/BRIEF.md
# General-Purpose I/O Bank Controller

This block controls a bank of general-purpose pins from a simple register bus. Software chooses the direction, output level, open-drain behaviour, weak pull-up request and change monitoring of each pin. Every writable register has four write addresses: a plain write and three atomic forms. The atomic forms clear, set or toggle only the bits written as 1, so software does not need a read-modify-write sequence.

A peripheral takes over a pin by raising that pin's override enable. The pin's data and drive then come from the peripheral, and the latch and direction settings are ignored. Pin inputs cross into the system clock domain through a two-flop synchronizer. Reads of the pin level and the change detector both see the synchronized value. The change detector compares each monitored pin with a snapshot that is refreshed whenever software reads the pin-level address. It raises a sticky interrupt when a monitored pin differs from its snapshot.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset the direction register reads all ones. The latch, open-drain, pull-up and monitor-enable registers read zero, the interrupt is low and no pin is driven.
- R2: Bus address = {sel[2:0], op[1:0]}. The sel codes are: 0 direction, 1 latch, 2 pin level, 3 open-drain, 4 pull-up, 5 monitor enable, 6 interrupt flag (read as bit 0). The op codes are: 0 plain write, 1 clear, 2 set, 3 invert. A read returns the register selected by sel, whatever the op.
- R3: A clear, set or invert write changes only the register bits written as 1. All other bits keep their value.
- R4: Writes to the pin-level address, with any op, update the latch. A read of sel 1 returns the latch, and a read of sel 2 returns the synchronized pin level.
- R5: When no override is active, a pin whose direction bit is 0 is driven with its latch bit. A pin whose direction bit is 1 is not driven.
- R6: When a pin's open-drain bit is 1 and its output data is 1, the pin is released (drive enable 0). When the open-drain bit is 1 and the data is 0, the pin is driven low.
- R7: When a pin's peripheral override enable is 1, the output data is the peripheral's data and the pin is driven (subject to R6), whatever the direction and latch bits hold.
- R8: A change on a pin input first appears in a pin-level read after the second rising clock edge.
- R9: When a monitored pin's synchronized level differs from its snapshot, the interrupt rises at the third edge after the pin changes. Pins whose monitor-enable bit is 0 never raise it.
- R10: A read of the pin-level address with the read strobe high copies the synchronized level into the snapshot at that edge.
- R11: The interrupt stays high until a write to sel 6 with data bit 0 = 1. If a difference is present in the same cycle as that write, the interrupt stays high.
- R12: The pull-up request outputs follow the pull-up register bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 5 | Register select and write op |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe (snapshots the pin level at sel 2) |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for busAddr (combinational) |
| pinIn | input | 16 | Asynchronous pin levels |
| pinOut | output | 16 | Output data per pin |
| pinOe | output | 16 | Drive enable per pin |
| pullUpEn | output | 16 | Weak pull-up request per pin |
| perOe | input | 16 | Peripheral override enable per pin |
| perOut | input | 16 | Peripheral output data per pin |
| cnIrq | output | 1 | Change-notification interrupt |

## Verification
A flag-clear write and a freshly detected change can land in the same clock cycle. The bench provokes this by flipping a monitored pin and then timing the clear write so that it hits the edge at which the synchronized level first differs from the snapshot. The check requires the interrupt to read high just after that edge. A design that gives the clear priority would show it low for one cycle, which makes the collision visible. Before this, a separate sequence takes a snapshot and then clears the flag, to show that the clear does work when no change is present.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_CLR   = 2'd1,
    OP_SET   = 2'd2,
    OP_INV   = 2'd3
  } aliasOp_t;

  typedef enum logic [2:0] {
    SEL_DIR   = 3'd0,
    SEL_LAT   = 3'd1,
    SEL_PIN   = 3'd2,
    SEL_ODC   = 3'd3,
    SEL_PULL  = 3'd4,
    SEL_CNEN  = 3'd5,
    SEL_FLAG  = 3'd6,
    SEL_NONE  = 3'd7
  } regSel_t;

  typedef struct packed {
    logic     wrDir;
    logic     wrLat;
    logic     wrOdc;
    logic     wrPull;
    logic     wrCnEn;
    logic     clrFlag;
    logic     snapPin;
    aliasOp_t op;
    regSel_t  rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/gpio_bank_ctrl_unit.sv
module gpio_bank_ctrl_unit
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              clrBit,
  output ctrlStrobes_t      strobes
);

  regSel_t  sel;
  aliasOp_t op;

  assign sel = regSel_t'(busAddr[4:2]);
  assign op  = aliasOp_t'(busAddr[1:0]);

  always_comb begin
    strobes         = '0;
    strobes.op      = op;
    strobes.rdSel   = sel;
    strobes.snapPin = busRdEn && (sel == SEL_PIN);
    if (busWrEn) begin
      unique case (sel)
        SEL_DIR:  strobes.wrDir  = 1'b1;
        SEL_LAT,
        SEL_PIN:  strobes.wrLat  = 1'b1;
        SEL_ODC:  strobes.wrOdc  = 1'b1;
        SEL_PULL: strobes.wrPull = 1'b1;
        SEL_CNEN: strobes.wrCnEn = 1'b1;
        SEL_FLAG: strobes.clrFlag = clrBit;
        default:  ;
      endcase
    end
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrDir, strobes.wrLat, strobes.wrOdc, strobes.wrPull,
              strobes.wrCnEn, strobes.clrFlag})) else $error("one write"); // R2

endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [NUM_PINS-1:0] busWrData,
  output logic [NUM_PINS-1:0] busRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] pullUpEn,
  input  logic [NUM_PINS-1:0] perOe,
  input  logic [NUM_PINS-1:0] perOut,
  output logic                cnIrq
);

  localparam logic [NUM_PINS-1:0] ALL_ONES = {NUM_PINS{1'b1}};

  logic [NUM_PINS-1:0] dirReg, latReg, odcReg, pullReg, cnEnReg, snapReg;
  logic [NUM_PINS-1:0] pinLevel, diffBits;
  logic                cnFlag, anyChange;
  logic [NUM_PINS-1:0] syncChain [SYNC_STAGES];

  function automatic logic [NUM_PINS-1:0] applyOp(
    input logic [NUM_PINS-1:0] cur,
    input logic [NUM_PINS-1:0] wd,
    input aliasOp_t            op
  );
    unique case (op)
      OP_WRITE: applyOp = wd;
      OP_CLR:   applyOp = cur & ~wd;
      OP_SET:   applyOp = cur | wd;
      OP_INV:   applyOp = cur ^ wd;
      default:  applyOp = cur;
    endcase
  endfunction

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg  <= ALL_ONES;
      latReg  <= '0;
      odcReg  <= '0;
      pullReg <= '0;
      cnEnReg <= '0;
    end else begin
      if (strobes.wrDir)  dirReg  <= applyOp(dirReg,  busWrData, strobes.op);
      if (strobes.wrLat)  latReg  <= applyOp(latReg,  busWrData, strobes.op);
      if (strobes.wrOdc)  odcReg  <= applyOp(odcReg,  busWrData, strobes.op);
      if (strobes.wrPull) pullReg <= applyOp(pullReg, busWrData, strobes.op);
      if (strobes.wrCnEn) cnEnReg <= applyOp(cnEnReg, busWrData, strobes.op);
    end
  end

  // input synchronizer
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)      syncChain[s] <= '0;
        else if (s == 0) syncChain[s] <= pinIn;
        else            syncChain[s] <= syncChain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pinLevel = syncChain[SYNC_STAGES-1];

  // change notification
  assign diffBits  = (pinLevel ^ snapReg) & cnEnReg;
  assign anyChange = |diffBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapReg <= '0;
      cnFlag  <= 1'b0;
    end else begin
      if (strobes.snapPin) snapReg <= pinLevel;
      cnFlag <= (cnFlag & ~strobes.clrFlag) | anyChange;
    end
  end

  assign cnIrq    = cnFlag;
  assign pullUpEn = pullReg;

  // output multiplexers, one per pin
  genvar p;
  generate
    for (p = 0; p < NUM_PINS; p++) begin : gPin
      logic dataSel, driveSel;
      always_comb begin
        if (perOe[p]) begin
          dataSel  = perOut[p];
          driveSel = 1'b1;
        end else begin
          dataSel  = latReg[p];
          driveSel = ~dirReg[p];
        end
      end
      assign pinOut[p] = dataSel;
      assign pinOe[p]  = driveSel & ~(odcReg[p] & dataSel);
    end
  endgenerate

  // readback
  always_comb begin
    unique case (strobes.rdSel)
      SEL_DIR:  busRdData = dirReg;
      SEL_LAT:  busRdData = latReg;
      SEL_PIN:  busRdData = pinLevel;
      SEL_ODC:  busRdData = odcReg;
      SEL_PULL: busRdData = pullReg;
      SEL_CNEN: busRdData = cnEnReg;
      SEL_FLAG: busRdData = {{(NUM_PINS-1){1'b0}}, cnFlag};
      default:  busRdData = '0;
    endcase
  end

  AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrLat && strobes.op == OP_SET) |=>
      ((latReg & $past(busWrData)) == $past(busWrData)) &&
      ((latReg & ~$past(busWrData)) == ($past(latReg) & ~$past(busWrData))))
    else $error("set alias"); // R3
  AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrLat && strobes.op == OP_CLR) |=>
      ((latReg & $past(busWrData)) == '0) &&
      ((latReg & ~$past(busWrData)) == ($past(latReg) & ~$past(busWrData))))
    else $error("clr alias"); // R3
  AST_ODC_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOe & odcReg & pinOut) == '0)) else $error("odc release"); // R6
  AST_PERIPH_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    ((perOe & ~odcReg & ~pinOe) == '0)) else $error("periph drive"); // R7
  AST_CHANGE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    anyChange |=> cnFlag) else $error("change sets"); // R9
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cnFlag && !strobes.clrFlag) |=> cnFlag) else $error("flag hold"); // R11

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [NUM_PINS-1:0] busWrData,
  output logic [NUM_PINS-1:0] busRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] pullUpEn,
  input  logic [NUM_PINS-1:0] perOe,
  input  logic [NUM_PINS-1:0] perOut,
  output logic                cnIrq
);

  ctrlStrobes_t strobes;

  gpio_bank_ctrl_unit #(.ADDR_W(ADDR_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .clrBit  (busWrData[0]),
    .strobes (strobes)
  );

  gpio_bank_datapath #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .pinIn     (pinIn),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .pullUpEn  (pullUpEn),
    .perOe     (perOe),
    .perOut    (perOut),
    .cnIrq     (cnIrq)
  );

endmodule

// File: tb/gpio_bank_ctrl_test.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [15:0] busWrData = '0, busRdData;
  logic [15:0] pinIn = '0, pinOut, pinOe, pullUpEn;
  logic [15:0] perOe = '0, perOut = '0;
  logic        cnIrq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_bank_ctrl uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .pullUpEn(pullUpEn),
    .perOe(perOe), .perOut(perOut), .cnIrq(cnIrq)
  );

  // {write addr, write data, read addr, expected}
  localparam logic [41:0] VEC [9] = '{
    {5'h04, 16'h00F0, 5'h04, 16'h00F0},  // R2 plain latch write
    {5'h06, 16'h0F00, 5'h04, 16'h0FF0},  // R3 set
    {5'h05, 16'h0030, 5'h04, 16'h0FC0},  // R3 clear
    {5'h07, 16'hFFFF, 5'h04, 16'hF03F},  // R3 invert
    {5'h08, 16'h1234, 5'h04, 16'h1234},  // R4 pin addr writes latch
    {5'h0A, 16'h8000, 5'h04, 16'h9234},  // R4 set through pin addr
    {5'h01, 16'h00FF, 5'h00, 16'hFF00},  // R3 clear direction
    {5'h0F, 16'h0005, 5'h0C, 16'h0005},  // R3 invert open-drain
    {5'h12, 16'h0101, 5'h10, 16'h0101}   // R3 set pull-up
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [15:0] v);
    busAddr = a;
    #0.5;
    v = busRdData;
  endtask

  task automatic snapshot();
    @(negedge clk);
    busAddr = 5'h08; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic finish();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish();
      end
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(5'h00, v); check("R1 dir", v, 16'hFFFF);
    peek(5'h04, v); check("R1 lat", v, 16'h0000);
    peek(5'h0C, v); check("R1 odc", v, 16'h0000);
    peek(5'h10, v); check("R1 pull", v, 16'h0000);
    peek(5'h14, v); check("R1 cnen", v, 16'h0000);
    peek(5'h18, v); check("R1 flag", v, 16'h0000);
    check("R1 pinOe", pinOe, 16'h0000);
    check("R1 cnIrq", {15'b0, cnIrq}, 16'h0000);

    // register table
    for (int i = 0; i < 9; i++) begin
      busWrite(VEC[i][41:37], VEC[i][36:21]);
      peek(VEC[i][20:16], v);
      check($sformatf("R2/R3/R4 vector %0d", i), v, VEC[i][15:0]);
    end

    // R12 pull-up outputs
    check("R12 pullUpEn", pullUpEn, 16'h0101);

    // R5/R6 output drive: lat 9234, dir FF00, odc 0005
    #0.5;
    check("R5/R6 pinOe", pinOe, 16'h00FB);
    check("R5 pinOut[4]", {15'b0, pinOut[4]}, 16'h0001);
    check("R6 pinOut[0] low driven", {15'b0, pinOut[0]}, 16'h0000);

    // R7 peripheral override
    @(negedge clk);
    perOe = 16'h0104; perOut = 16'h0100;
    #0.5;
    check("R7 pinOe", pinOe, 16'h01FF);
    check("R7 pinOut[8]", {15'b0, pinOut[8]}, 16'h0001);
    check("R7 pinOut[2]", {15'b0, pinOut[2]}, 16'h0000);
    perOe = 16'h0000;

    // R8 synchronizer latency
    @(negedge clk);
    pinIn = 16'hA5A5; busAddr = 5'h08;
    @(posedge clk); #1;
    check("R8 after one edge", busRdData, 16'h0000);
    @(posedge clk); #1;
    check("R8 after two edges", busRdData, 16'hA5A5);
    peek(5'h04, v); check("R4 latch read unchanged", v, 16'h9234);

    // R10 snapshot then enable monitoring of pins 0,1
    snapshot();
    busWrite(5'h14, 16'h0003);
    repeat (3) @(negedge clk);
    check("R10 no flag after snapshot", {15'b0, cnIrq}, 16'h0000);

    // R9 disabled pin ignored
    pinIn = 16'hA5B5;
    repeat (4) @(negedge clk);
    check("R9 disabled pin ignored", {15'b0, cnIrq}, 16'h0000);

    // R9 monitored pin raises flag on third edge
    pinIn = 16'hA5B7;
    @(posedge clk); @(posedge clk); #1;
    check("R9 flag low at edge 2", {15'b0, cnIrq}, 16'h0000);
    @(posedge clk); #1;
    check("R9 flag high at edge 3", {15'b0, cnIrq}, 16'h0001);

    // R11 clear with persisting difference, sticky
    busWrite(5'h18, 16'h0001);
    repeat (2) @(negedge clk);
    check("R11 flag held while difference remains", {15'b0, cnIrq}, 16'h0001);

    // R10/R11 snapshot then clear
    snapshot();
    busWrite(5'h18, 16'h0001);
    check("R11 flag cleared", {15'b0, cnIrq}, 16'h0000);
    peek(5'h18, v); check("R2 flag readback", v, 16'h0000);

    // R11 collision: clear in same cycle as a new difference
    pinIn = 16'hA5B6;            // at a falling edge
    @(negedge clk);              // edge 1 done
    @(negedge clk);              // edge 2 done: difference present
    busAddr = 5'h18; busWrData = 16'h0001; busWrEn = 1'b1;
    @(negedge clk);              // edge 3: clear and set together
    busWrEn = 1'b0;
    check("R11 set wins over clear", {15'b0, cnIrq}, 16'h0001);

    done = 1'b1;
    finish();
  end

endmodule